// File: doc/BRIEF.md
# Debounced Auto-Repeat Code Counter

This block keeps one channel's code for a pulse-width output stage. The code is a small register that software never writes. It changes only in response to a single control input, and that input is read in one of two ways, selected by a mode pin.

In pulse mode the input is an ordinary logic clock. After a two-flop synchroniser, each rising edge adds one to the code, and the code wraps past the top.

In pushbutton mode the input is a three-level button state: pressed high, pressed low, or floating. The state is debounced on a slow timing tick. Each accepted press moves the code one step up or down, clamped at the ends. Holding the button starts an auto-repeat after a long delay, and the repeat then continues at a steady rate.

A shutdown input freezes the code and ignores all input activity. Reset loads midscale. Every timing constant is counted in ticks of the shared slow enable, so the bench can shrink them.

Top module: `code_stepper`

## Requirements
- R1: While reset is asserted, and on the cycle after it, the code reads midscale, which is 2^(CODE_W-1) (32 by default).
- R2: In pulse mode, each rising edge of `pulse_in` adds one to the code, and the code wraps from the maximum to 0. Applying 2^CODE_W-1 edges therefore lowers the code by one.
- R3: In pushbutton mode, a press toward high (`btn_lvl` = 2'b01) raises the code by one per step, and the code stays at the maximum once it reaches it.
- R4: In pushbutton mode, a press toward low (`btn_lvl` = 2'b10) lowers the code by one per step, and the code stays at 0 once it reaches it. The values 2'b00 and 2'b11 both mean floating.
- R5: A button level changes the accepted state only after it has been seen on DEB_TICKS consecutive ticks, counting the first tick that sees it. A press shorter than that makes no step. An accepted press makes exactly one step, on its accepting tick.
- R6: While an accepted press stays accepted, a second step occurs HOLD_TICKS ticks after the accepting tick.
- R7: After that second step, further steps occur every REP_TICKS ticks until a floating level is accepted. The accepting tick of the release makes no step. This gives 1 + (N > HOLD_TICKS ? 1 + (N-1-HOLD_TICKS)/REP_TICKS : 0) steps for a press seen on N ≥ DEB_TICKS ticks.
- R8: While `shdn` is high, the code does not change. Pulse edges and button activity during that time have no effect after `shdn` falls, provided the button is floating at that point.
- R9: In pushbutton mode, `pulse_in` has no effect. In pulse mode, `btn_lvl` has no effect.
- R10: The code changes by at most one step per clock cycle, and only on a pulse edge or a button step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle slow timing enable (320 kHz nominal) |
| mode_pulse | input | 1 | 1 selects pulse mode, 0 selects pushbutton mode |
| shdn | input | 1 | High freezes the code and ignores inputs |
| pulse_in | input | 1 | Asynchronous clock input used in pulse mode |
| btn_lvl | input | 2 | Button state: 01 high, 10 low, 00 or 11 floating |
| code_o | output | CODE_W | Current code |

## Verification
The hardest situation to reach is the boundary of the hold and repeat windows. A press that ends one tick before or one tick after a repeat instant must give different step counts, and the release debounce keeps stepping for DEB_TICKS-1 ticks after the button lets go. The bench drives the timing tick itself and shrinks every constant. It places button changes between ticks, so each press is seen on an exact number of ticks. Directed presses sit at DEB_TICKS-1, DEB_TICKS, HOLD_TICKS, HOLD_TICKS+1 and one repeat beyond. Random press lengths and directions then run against a closed-form step count with clamping at both ends.

// File: rtl/code_stepper_pkg.sv
package code_stepper_pkg;
  typedef enum logic [1:0] {
    LV_FLOAT = 2'd0,
    LV_UP    = 2'd1,
    LV_DN    = 2'd2
  } lvl_e;

  // Three-level button decode; 00 and 11 are both treated as floating.
  function automatic lvl_e decode_lvl(input logic [1:0] raw);
    case (raw)
      2'b01:   return LV_UP;
      2'b10:   return LV_DN;
      default: return LV_FLOAT;
    endcase
  endfunction
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cs_btn_timer.sv
module cs_btn_timer
  import code_stepper_pkg::*;
#(
  parameter int DEB_TICKS  = 4096,
  parameter int HOLD_TICKS = 131072,
  parameter int REP_TICKS  = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  lvl_e raw,
  output logic step_up,
  output logic step_dn
);
  localparam int DW = (DEB_TICKS  > 2) ? $clog2(DEB_TICKS)  : 1;
  localparam int HW = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
  localparam int RW = (REP_TICKS  > 2) ? $clog2(REP_TICKS)  : 1;

  lvl_e          cand, stable;
  logic [DW-1:0] deb_cnt;
  logic [HW-1:0] hold_cnt;
  logic [RW-1:0] rep_cnt;
  logic          repeating;

  logic settle_chg, press_ev, hold_ev, repeat_ev, held, go_up;

  always_comb begin
    settle_chg = tick && (raw == cand) && (deb_cnt == DW'(DEB_TICKS - 2)) && (cand != stable);
    press_ev   = settle_chg && (cand != LV_FLOAT);
    held       = (stable != LV_FLOAT);
    hold_ev    = tick && held && !settle_chg && !repeating && (hold_cnt == HW'(HOLD_TICKS - 1));
    repeat_ev  = tick && held && !settle_chg && repeating && (rep_cnt == RW'(REP_TICKS - 1));
    go_up      = press_ev ? (cand == LV_UP) : (stable == LV_UP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cand      <= LV_FLOAT;
      stable    <= LV_FLOAT;
      deb_cnt   <= '0;
      hold_cnt  <= '0;
      rep_cnt   <= '0;
      repeating <= 1'b0;
      step_up   <= 1'b0;
      step_dn   <= 1'b0;
    end else begin
      step_up <= (press_ev || hold_ev || repeat_ev) && go_up;
      step_dn <= (press_ev || hold_ev || repeat_ev) && !go_up;
      if (tick) begin
        if (raw != cand) begin
          cand    <= raw;
          deb_cnt <= '0;
        end else if (deb_cnt != DW'(DEB_TICKS - 1)) begin
          deb_cnt <= deb_cnt + 1'b1;
        end

        if (settle_chg) begin
          stable    <= cand;
          hold_cnt  <= '0;
          rep_cnt   <= '0;
          repeating <= 1'b0;
        end else if (held) begin
          if (!repeating) begin
            if (hold_ev) begin
              repeating <= 1'b1;
              rep_cnt   <= '0;
            end else begin
              hold_cnt <= hold_cnt + 1'b1;
            end
          end else begin
            rep_cnt <= repeat_ev ? '0 : rep_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cs_code_reg.sv
module cs_code_reg #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_wrap,
  input  logic              inc_sat,
  input  logic              dec_sat,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP = '1;

  function automatic logic [CODE_W-1:0] wrap_up(input logic [CODE_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic [CODE_W-1:0] clamp_up(input logic [CODE_W-1:0] c);
    return (c == TOP) ? c : c + 1'b1;
  endfunction

  function automatic logic [CODE_W-1:0] clamp_dn(input logic [CODE_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        code <= MID;
    else if (inc_wrap) code <= wrap_up(code);
    else if (inc_sat)  code <= clamp_up(code);
    else if (dec_sat)  code <= clamp_dn(code);
  end
endmodule

// File: rtl/code_stepper.sv
module code_stepper
  import code_stepper_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int DEB_TICKS  = 4096,
  parameter int HOLD_TICKS = 131072,
  parameter int REP_TICKS  = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_pulse,
  input  logic              shdn,
  input  logic              pulse_in,
  input  logic [1:0]        btn_lvl,
  output logic [CODE_W-1:0] code_o
);
  logic       pulse_s, pulse_d, pulse_rise;
  logic [1:0] btn_s;
  logic       btn_clear, step_up, step_dn;
  logic       wrap_ev, up_ev, dn_ev;

  cs_sync #(.W(1)) u_pulse_sync (
    .clk(clk), .rst_n(rst_n), .d(pulse_in), .q(pulse_s)
  );

  cs_sync #(.W(2)) u_btn_sync (
    .clk(clk), .rst_n(rst_n), .d(btn_lvl), .q(btn_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_d <= 1'b0;
    else        pulse_d <= pulse_s;
  end

  assign pulse_rise = pulse_s & ~pulse_d;
  assign btn_clear  = mode_pulse | shdn;

  cs_btn_timer #(
    .DEB_TICKS(DEB_TICKS), .HOLD_TICKS(HOLD_TICKS), .REP_TICKS(REP_TICKS)
  ) u_btn_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(btn_clear),
    .raw(decode_lvl(btn_s)), .step_up(step_up), .step_dn(step_dn)
  );

  assign wrap_ev = mode_pulse  & ~shdn & pulse_rise;
  assign up_ev   = ~mode_pulse & ~shdn & step_up;
  assign dn_ev   = ~mode_pulse & ~shdn & step_dn;

  cs_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .inc_wrap(wrap_ev), .inc_sat(up_ev),
    .dec_sat(dn_ev), .code(code_o)
  );
endmodule

// File: rtl/code_stepper_chk.sv
module code_stepper_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_pulse,
  input logic              shdn,
  input logic              wrap_ev,
  input logic              up_ev,
  input logic              dn_ev,
  input logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TOP = '1;

  assert_reset_mid_R1: assert property (@(posedge clk) !rst_n |=> code_o == MID);

  assert_pulse_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> code_o == CODE_W'($past(code_o) + 1'b1));

  assert_up_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_ev |=> code_o == (($past(code_o) == TOP) ? TOP : CODE_W'($past(code_o) + 1'b1)));

  assert_dn_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_ev |=> code_o == (($past(code_o) == '0) ? '0 : CODE_W'($past(code_o) - 1'b1)));

  assert_shdn_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> code_o == $past(code_o));

  assert_mode_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pulse && !wrap_ev) |=> code_o == $past(code_o));

  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrap_ev, up_ev, dn_ev}));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_ev || up_ev || dn_ev) |=> code_o == $past(code_o));
endmodule

bind code_stepper code_stepper_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_pulse(mode_pulse), .shdn(shdn),
  .wrap_ev(wrap_ev), .up_ev(up_ev), .dn_ev(dn_ev), .code_o(code_o)
);

// File: tb/code_stepper_bench.sv
module code_stepper_bench;
  localparam int CW   = 6;
  localparam int DEB  = 8;
  localparam int HOLD = 48;
  localparam int REP  = 12;
  localparam int TOP  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          mode_pulse = 1'b1;
  logic          shdn = 1'b0;
  logic          pulse_in = 1'b0;
  logic [1:0]    btn_lvl = 2'b00;
  logic [CW-1:0] code_o;

  int n_chk = 0;
  int n_fail = 0;
  int model = 32;

  always #2 clk = ~clk;

  code_stepper #(
    .CODE_W(CW), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .REP_TICKS(REP)
  ) u_code_stepper (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_pulse(mode_pulse), .shdn(shdn),
    .pulse_in(pulse_in), .btn_lvl(btn_lvl), .code_o(code_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: code actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Step count for a press seen on n ticks (R5, R6, R7).
  function automatic int press_steps(input int n);
    if (n < DEB) return 0;
    if (n <= HOLD) return 1;
    return 2 + (n - 1 - HOLD) / REP;
  endfunction

  function automatic int clamp_move(input int c, input int steps, input bit up);
    int v = c;
    for (int i = 0; i < steps; i++) v = up ? ((v < TOP) ? v + 1 : v) : ((v > 0) ? v - 1 : v);
    return v;
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1; repeat (3) @(negedge clk);
      pulse_in = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic press(input bit up, input int n, input string req);
    btn_lvl = up ? 2'b01 : 2'b10;
    ticks(n);
    btn_lvl = ($urandom_range(0, 1) == 1) ? 2'b11 : 2'b00;
    ticks(DEB + 2);
    repeat (4) @(negedge clk);
    model = clamp_move(model, press_steps(n), up);
    check(req, int'(code_o), model);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1426));
    repeat (4) @(negedge clk);
    check("R1 in reset", int'(code_o), 32);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", int'(code_o), 32);

    // R2: pulse mode wrap
    pulses(31); model = 63; check("R2 up to top", int'(code_o), model);
    pulses(1);  model = 0;  check("R2 wrap to zero", int'(code_o), model);
    pulses(5);  model = 5;
    pulses(63); model = 4;  check("R2 63 edges lower by one", int'(code_o), model);
    for (int k = 0; k < 4; k++) begin
      int n = $urandom_range(1, 70);
      pulses(n);
      model = (model + n) % 64;
      check("R2 random edges", int'(code_o), model);
    end

    // R8: shutdown in pulse mode
    shdn = 1'b1; pulses(7);
    check("R8 shdn holds in pulse mode", int'(code_o), model);
    shdn = 1'b0; repeat (4) @(negedge clk);
    check("R8 after shdn release", int'(code_o), model);

    // R9: button ignored in pulse mode
    btn_lvl = 2'b01; ticks(HOLD + 3 * REP); btn_lvl = 2'b00; ticks(DEB + 2);
    check("R9 button ignored in pulse mode", int'(code_o), model);

    // Pushbutton mode
    mode_pulse = 1'b0;
    repeat (4) @(negedge clk);
    pulses(9);
    check("R9 pulse ignored in pushbutton mode", int'(code_o), model);

    press(1'b1, DEB - 1, "R5 short press no step");
    press(1'b1, DEB, "R5 minimum press one step");
    press(1'b0, HOLD, "R6 press ending at hold");
    press(1'b0, HOLD + 1, "R6 second step at hold");
    press(1'b1, HOLD + REP, "R7 just before repeat");
    press(1'b1, HOLD + REP + 1, "R7 first repeat");

    // Saturation corners
    press(1'b1, HOLD + 1 + 70 * REP, "R3 clamp at top");
    check("R3 code at top", int'(code_o), TOP);
    press(1'b1, DEB, "R3 press at top stays");
    press(1'b0, HOLD + 1 + 70 * REP, "R4 clamp at zero");
    check("R4 code at zero", int'(code_o), 0);
    press(1'b0, DEB + 3, "R4 press at zero stays");

    for (int k = 0; k < 14; k++) begin
      press($urandom_range(0, 1) == 1, $urandom_range(DEB - 2, HOLD + 5 * REP),
            "R7 random press");
    end

    // R8: shutdown in pushbutton mode
    shdn = 1'b1;
    btn_lvl = 2'b10; ticks(HOLD + 2 * REP);
    btn_lvl = 2'b00; ticks(2);
    shdn = 1'b0; ticks(DEB + 2);
    check("R8 shdn holds in pushbutton mode", int'(code_o), model);
    check("R10 code stable with no events", int'(code_o), model);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule